// File: doc/BRIEF.md
# Symmetric Up/Down Pulse-Width Modulator

This block drives one pulse-width modulated pin from a counter that climbs from zero to a ceiling, turns, and falls back to zero. Because the waveform is mirrored about the ceiling, every pulse is centred in its period, and the pulse width changes symmetrically about that centre. Three resolutions are available, with ceilings of 255, 511 and 1023. Once `enable` is set, the block runs with no further intervention. A second output gives a single-clock marker each time the counter lands on zero.

The 16-bit duty word on `cmpIn` is masked to the active resolution. It is taken into the active compare register only when the counter sits at its ceiling, so a new duty value never cuts a pulse short. A new resolution code is taken only when the counter sits at zero, so the counter can never be left above a ceiling that has just shrunk. A polarity input selects the inverted output waveform.

Top module: `pwm_updown`

## Requirements
- R1: After reset, `pwmOut` and `atBottom` are 0. The internal counter is 0 and counting up, the active compare value is 0, and the active resolution is 8-bit.
- R2: While `enable` is 1, the counter moves one step per clock. It rises to the ceiling, falls to zero, and repeats, so successive `atBottom` pulses are exactly 2×ceiling clocks apart.
- R3: The resolution code `resSel` sets the ceiling as follows: 0 gives 255, 1 gives 511, and both 2 and 3 give 1023.
- R4: Only the low bits of `cmpIn` take part in the match, namely `cmpIn` ANDed with the active ceiling. For example, 16'hAB64 at 8-bit resolution acts as 100.
- R5: With `invert` at 0 and an effective compare C where 0 < C < ceiling, `pwmOut` goes low on the match while counting up and high on the match while counting down. The pin is therefore high while the counter is below C (2C−1 clocks per period), and it follows the counter one clock later.
- R6: With `invert` at 1, `pwmOut` is the complement of the R5 waveform, giving 2×ceiling−(2C−1) high clocks per period.
- R7: With `invert` at 0, an effective compare of 0 holds `pwmOut` low for the whole period, and an effective compare equal to the ceiling holds it high for the whole period.
- R8: `cmpIn` is copied into the active compare register only on an enabled clock where the counter is at the ceiling. Changes at any other time have no effect until that point.
- R9: `atBottom` is a one-clock pulse, high in the clock where the counter has just stepped down to 0. It only follows an enabled clock.
- R10: While `enable` is 0, the counter, direction, `pwmOut` and both active registers hold, and `atBottom` stays 0. When `enable` returns to 1, counting resumes from the held value.
- R11: `resSel` is copied into the active resolution only on an enabled clock where the counter is 0. A mid-period change leaves the current period at the old ceiling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counting enable; 0 freezes the block |
| resSel | input | 2 | Resolution code: 0 = 8-bit, 1 = 9-bit, 2 or 3 = 10-bit |
| cmpIn | input | 16 | Duty compare word, buffered until the ceiling |
| invert | input | 1 | 1 selects the inverted output waveform |
| pwmOut | output | 1 | Registered PWM output |
| atBottom | output | 1 | One-clock pulse when the counter reaches zero |

## Verification
A wrong direction flag or counter value shows up as a wrong gap between `atBottom` pulses, and it is visible by the next pulse at the latest, one period later. A fault in the active compare register or its mask shows up as a wrong count of high clocks over a single period. A compare register that loads at the wrong moment is caught within a hundred clocks of a duty change made at the bottom, because on the rising slope the pin would already follow the new value. A resolution that is taken mid-period moves the very next `atBottom` pulse earlier. A broken freeze shows up at once as a change on `pwmOut` or a pulse on `atBottom` while `enable` is low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Strobes passed from the sequencing control to the datapath each clock.
  typedef struct packed {
    logic step;       // advance the counter this clock
    logic goUp;       // direction for this step
    logic loadCmp;    // counter at ceiling: take the buffered duty word
    logic loadRes;    // counter at zero: take the resolution code
    logic hitBottom;  // this step lands the counter on zero
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_updown_ctrl.sv
module pwm_updown_ctrl
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       atTop,
  input  logic       atZero,
  input  logic       nearZero,
  output pwmStrobe_t strobe
);

  logic dirUp;
  logic nextUp;

  // The direction turns at both ends, otherwise it keeps its heading.
  always_comb begin
    if (atTop)       nextUp = 1'b0;
    else if (atZero) nextUp = 1'b1;
    else             nextUp = dirUp;
  end

  always_comb begin
    strobe.step      = enable;
    strobe.goUp      = nextUp;
    strobe.loadCmp   = enable && atTop;
    strobe.loadRes   = enable && atZero;
    strobe.hitBottom = enable && nearZero && !nextUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dirUp <= 1'b1;
    else if (enable) dirUp <= nextUp;
  end

endmodule

// File: rtl/pwm_updown_dp.sv
module pwm_updown_dp
  import pwm_pkg::*;
#(
  parameter int MIN_W   = 8,
  parameter int NUM_RES = 3,
  parameter int CMP_W   = 16,
  parameter int RES_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] resSel,
  input  logic [CMP_W-1:0] cmpIn,
  input  logic             invert,
  input  pwmStrobe_t       strobe,
  output logic             atTop,
  output logic             atZero,
  output logic             nearZero,
  output logic             pwmOut,
  output logic             atBottom
);

  localparam int CNT_W = MIN_W + NUM_RES - 1;
  localparam logic [RES_W-1:0] LAST_RES = RES_W'(NUM_RES - 1);

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] cmpAct;
  logic [RES_W-1:0] resAct;
  logic [RES_W-1:0] resIdx;
  logic [CNT_W-1:0] topTab [NUM_RES];
  logic [CNT_W-1:0] top;
  logic [CMP_W-1:0] topWide;
  logic [CMP_W-1:0] effCmp;
  logic [CMP_W-1:0] cntWide;
  logic             level;

  // One ceiling per resolution step, all ones at MIN_W + g bits.
  for (genvar g = 0; g < NUM_RES; g++) begin : g_top
    assign topTab[g] = CNT_W'((1 << (MIN_W + g)) - 1);
  end

  // Codes past the last resolution use the widest one.
  assign resIdx  = (resAct > LAST_RES) ? LAST_RES : resAct;
  assign top     = topTab[resIdx];
  assign topWide = CMP_W'(top);
  assign cntWide = CMP_W'(cnt);
  assign effCmp  = cmpAct & topWide;

  assign atTop    = (cnt == top);
  assign atZero   = (cnt == '0);
  assign nearZero = (cnt == CNT_W'(1));

  // A zero compare never turns the pin on, and a compare at the ceiling
  // never turns it off. Otherwise the pin is on below the compare value.
  always_comb begin
    if (effCmp == '0)         level = 1'b0;
    else if (effCmp == topWide) level = 1'b1;
    else                      level = (cntWide < effCmp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.step) begin
      if (strobe.goUp) cnt <= cnt + CNT_W'(1);
      else             cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cmpAct <= '0;
    else if (strobe.loadCmp) cmpAct <= cmpIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resAct <= '0;
    else if (strobe.loadRes) resAct <= resSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut   <= 1'b0;
      atBottom <= 1'b0;
    end else begin
      atBottom <= strobe.hitBottom;
      if (strobe.step) pwmOut <= level ^ invert;
    end
  end

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown
  import pwm_pkg::*;
#(
  parameter int MIN_W   = 8,
  parameter int NUM_RES = 3,
  parameter int CMP_W   = 16,
  parameter int RES_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [RES_W-1:0] resSel,
  input  logic [CMP_W-1:0] cmpIn,
  input  logic             invert,
  output logic             pwmOut,
  output logic             atBottom
);

  pwmStrobe_t strobe;
  logic       atTop;
  logic       atZero;
  logic       nearZero;

  pwm_updown_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .atTop    (atTop),
    .atZero   (atZero),
    .nearZero (nearZero),
    .strobe   (strobe)
  );

  pwm_updown_dp #(
    .MIN_W   (MIN_W),
    .NUM_RES (NUM_RES),
    .CMP_W   (CMP_W),
    .RES_W   (RES_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .resSel   (resSel),
    .cmpIn    (cmpIn),
    .invert   (invert),
    .strobe   (strobe),
    .atTop    (atTop),
    .atZero   (atZero),
    .nearZero (nearZero),
    .pwmOut   (pwmOut),
    .atBottom (atBottom)
  );

endmodule

// File: rtl/pwm_updown_chk.sv
module pwm_updown_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic pwmOut,
  input logic atBottom
);

  // R9
  bottom_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    atBottom |=> !atBottom);

  // R9
  bottom_after_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    atBottom |-> $past(enable));

  // R10
  freeze_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(pwmOut));

  // R10
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !atBottom);

endmodule

bind pwm_updown pwm_updown_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .pwmOut   (pwmOut),
  .atBottom (atBottom)
);

// File: tb/pwm_updown_bench.sv
module pwm_updown_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  resSel = 2'd0;
  logic [15:0] cmpIn = 16'd0;
  logic        invert = 1'b0;
  logic        pwmOut;
  logic        atBottom;

  int nErr = 0;
  int nChecks = 0;

  always #5 clk = ~clk;

  pwm_updown u_pwm_updown (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .resSel   (resSel),
    .cmpIn    (cmpIn),
    .invert   (invert),
    .pwmOut   (pwmOut),
    .atBottom (atBottom)
  );

  function automatic int ceilOf(input int code);
    if (code == 0)      return 255;
    else if (code == 1) return 511;
    else                return 1023;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs to the next bottom pulse, counting clocks and high samples.
  task automatic waitBottom(output int cyc, output int hi);
    cyc = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (pwmOut) hi++;
    end while (!atBottom && cyc < 5000);
  endtask

  task automatic settle();
    int c, h;
    waitBottom(c, h);
    waitBottom(c, h);
  endtask

  task automatic testReset();
    check(pwmOut == 1'b0, "R1 pwmOut in reset", int'(pwmOut), 0);
    check(atBottom == 1'b0, "R1 atBottom in reset", int'(atBottom), 0);
  endtask

  // R2 R3: period between bottoms for each resolution code
  task automatic testPeriod(input int code);
    int c, h;
    resSel = 2'(code);
    cmpIn  = 16'd10;
    settle();
    waitBottom(c, h);
    check(c == 2 * ceilOf(code), $sformatf("R2 R3 period code %0d", code), c, 2 * ceilOf(code));
  endtask

  task automatic testDuty(input int code, input int cmp, input bit inv, input int expHi, input string req);
    int c, h;
    resSel = 2'(code);
    cmpIn  = 16'(cmp);
    invert = inv;
    settle();
    waitBottom(c, h);
    check(c == 2 * ceilOf(code), {req, " period"}, c, 2 * ceilOf(code));
    check(h == expHi, {req, " high clocks"}, h, expHi);
  endtask

  // R9: pulse lasts a single clock
  task automatic testPulse();
    int c, h;
    resSel = 2'd0;
    waitBottom(c, h);
    check(atBottom == 1'b1, "R9 pulse seen", int'(atBottom), 1);
    @(negedge clk);
    check(atBottom == 1'b0, "R9 pulse width", int'(atBottom), 0);
  endtask

  // R8: a new duty word waits for the ceiling
  task automatic testBuffer();
    int c, h;
    resSel = 2'd0;
    invert = 1'b0;
    cmpIn  = 16'd50;
    settle();
    cmpIn = 16'd200;
    repeat (100) @(negedge clk);
    check(pwmOut == 1'b0, "R8 old compare on rising slope", int'(pwmOut), 0);
    waitBottom(c, h);
    waitBottom(c, h);
    check(h == 399, "R8 new compare after ceiling", h, 399);
  endtask

  // R10: freeze while disabled, resume from the held count
  task automatic testFreeze();
    int c, h, bad;
    logic held;
    resSel = 2'd0;
    cmpIn  = 16'd40;
    invert = 1'b0;
    settle();
    repeat (30) @(negedge clk);
    held   = pwmOut;
    enable = 1'b0;
    bad    = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut != held || atBottom) bad++;
    end
    check(bad == 0, "R10 outputs frozen while disabled", bad, 0);
    enable = 1'b1;
    waitBottom(c, h);
    check(c == 480, "R10 resume from held count", c, 480);
  endtask

  // R11: resolution taken only at zero
  task automatic testResChange();
    int c, h;
    resSel = 2'd2;
    cmpIn  = 16'd10;
    settle();
    repeat (300) @(negedge clk);
    resSel = 2'd0;
    waitBottom(c, h);
    check(c == 2046 - 300, "R11 current period keeps old ceiling", c, 1746);
    waitBottom(c, h);
    check(c == 510, "R11 next period uses new ceiling", c, 510);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN   = 1'b1;
    enable = 1'b1;
    for (int code = 0; code < 4; code++) testPeriod(code);
    testDuty(0, 100, 1'b0, 199, "R5 non-inverted C=100");
    testDuty(0, 1, 1'b0, 1, "R5 non-inverted C=1");
    testDuty(1, 300, 1'b0, 599, "R5 9-bit C=300");
    testDuty(0, 16'hAB64, 1'b0, 199, "R4 masked 0xAB64");
    testDuty(0, 100, 1'b1, 311, "R6 inverted C=100");
    testDuty(0, 0, 1'b0, 0, "R7 zero compare");
    testDuty(0, 255, 1'b0, 510, "R7 ceiling compare");
    testDuty(0, 16'h01FF, 1'b0, 510, "R4 R7 masked to ceiling");
    testDuty(2, 16'hFFFF, 1'b0, 2046, "R7 10-bit ceiling");
    testDuty(0, 0, 1'b1, 510, "R6 R7 inverted zero");
    invert = 1'b0;
    testPulse();
    testBuffer();
    testFreeze();
    testResChange();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule